// File: doc/BRIEF.md
# Byte-wide PROM programming sequencer

This controller burns a run of consecutive byte locations in a one-time or UV-erasable PROM. A single start request latches a first and a last address. For each location in turn the controller asks a data source for the byte and drives it with the address. It then applies a write strobe of fixed length and reads the cell back with the output strobe. It retries until the readback matches. Pulse lengths, setup and hold gaps and bus turn-around gaps are all counted in clock cycles set by parameters. This lets the same logic serve any clock rate.

The write-verify loop adapts to each cell. Each location may take up to a fixed number of attempts. Each attempt is a nominal 1 ms write strobe followed by a readback. When the readback first matches, after X attempts, the same byte is written once more with a strobe 3·X times as long, to give the cell margin. If the last allowed attempt still reads back wrong, the controller stops, raises a defective flag and keeps the failing address. When the last address has passed, it raises a done flag instead. Both flags stay up until the next start.

Top module: `prom_prog_seq`

## Requirements
- R1: After reset, and whenever idle, the chip-enable and output-enable strobes (`ce_n`, `oe_n`, active low) are high, the bus drive `wr_oe` is low, and `busy`, `done` and `fail` are low.
- R2: Each programming attempt holds `ce_n` low for exactly `PULSE_CYC` cycles, with `oe_n` high and the target byte driven on `wr_data`.
- R3: Every attempt is followed by a verify window in which `oe_n` is low for exactly `READ_CYC` cycles with `wr_oe` low. The `rd_data` byte sampled in the last cycle of the window is compared with the target byte, and a mismatch starts another attempt with the same byte.
- R4: When the verify after attempt X (counting from 1) matches, the same byte is written once more with `ce_n` low for exactly 3·X·`PULSE_CYC` cycles. No verify follows this pulse.
- R5: If the verify after attempt number `MAX_TRY` still mismatches, the controller raises `fail`, holds the current address on `fail_addr`, drops `busy`, and issues no further strobes.
- R6: Address and write data are driven and unchanged for at least `SETUP_CYC` cycles before `ce_n` falls, stay unchanged while `ce_n` is low, and stay driven and unchanged for at least `HOLD_CYC` cycles after `ce_n` rises.
- R7: `ce_n` and `oe_n` are never low together. `wr_oe` is low for at least `GAP_CYC` cycles before `oe_n` falls. `wr_oe` rises again only after `oe_n` has been high for at least `FLOAT_CYC` cycles.
- R8: Locations are programmed in ascending order from `start_addr` to `end_addr` inclusive, with `start_addr` not above `end_addr`. After the final location's extra pulse, `done` rises and `busy` falls.
- R9: For each location the byte is fetched once by raising `src_req` and taking `src_data` in the cycle `src_ack` is high. The attempt count restarts at zero for each location.
- R10: A `start` while `busy` is high has no effect. `done` and `fail` stay as they are until the next accepted `start`, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a programming run (taken only when idle) |
| start_addr | input | AW | First location of the run |
| end_addr | input | AW | Last location of the run |
| src_req | output | 1 | Request for the next byte |
| src_ack | input | 1 | Byte on src_data is valid this cycle |
| src_data | input | DW | Byte to program |
| rd_data | input | DW | Readback byte from the device data bus |
| ce_n | output | 1 | Chip-enable / program strobe, active low |
| oe_n | output | 1 | Output-enable strobe, active low |
| addr | output | AW | Device address |
| wr_data | output | DW | Byte driven to the device |
| wr_oe | output | 1 | Drive enable for wr_data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run ended with every location written |
| fail | output | 1 | Device judged defective |
| fail_addr | output | AW | Location that failed |

## Verification
The bench builds the block with `PULSE_CYC`=4, `SETUP_CYC`=2, `HOLD_CYC`=2, `GAP_CYC`=2, `READ_CYC`=2 and `FLOAT_CYC`=1. `MAX_TRY` keeps its value of 25 and the address is four bits wide. The short strobes mean a location that passes only on its 25th attempt costs a few hundred cycles. That location earns a 300-cycle margin pulse. A location that never passes reaches the defective exit within the run budget, so both edges of the attempt limit are exercised. A device model in the bench lets each cell need its own number of pulses. This gives every location a different attempt count and makes a missed per-location restart of the counter visible in the margin pulse width.

// File: rtl/prom_prog_seq.sv
module prom_prog_seq #(
  parameter int AW        = 15,
  parameter int DW        = 8,
  parameter int PULSE_CYC = 16000,
  parameter int SETUP_CYC = 32,
  parameter int HOLD_CYC  = 32,
  parameter int GAP_CYC   = 32,
  parameter int READ_CYC  = 16,
  parameter int FLOAT_CYC = 2,
  parameter int MAX_TRY   = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  output logic          src_req,
  input  logic          src_ack,
  input  logic [DW-1:0] src_data,
  input  logic [DW-1:0] rd_data,
  output logic          ce_n,
  output logic          oe_n,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_oe,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr
);
  localparam int TW      = $clog2(MAX_TRY + 1);
  localparam int LONGEST = 3 * MAX_TRY * PULSE_CYC;
  localparam int CW      = $clog2(LONGEST + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_SETUP, S_PULSE, S_HOLD, S_GAP, S_READ, S_FLOAT
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt, span;
  logic [TW-1:0] tries;
  logic [AW-1:0] addr_q, end_q, fail_addr_q;
  logic [DW-1:0] data_q;
  logic          over, match, done_q, fail_q;
  logic          timed, last;

  always_comb begin
    case (st)
      S_SETUP: span = CW'(SETUP_CYC);
      S_PULSE: span = over ? CW'(tries) * CW'(3 * PULSE_CYC) : CW'(PULSE_CYC);
      S_HOLD:  span = CW'(HOLD_CYC);
      S_GAP:   span = CW'(GAP_CYC);
      S_READ:  span = CW'(READ_CYC);
      S_FLOAT: span = CW'(FLOAT_CYC);
      default: span = CW'(1);
    endcase
  end

  assign timed = (st != S_IDLE) && (st != S_FETCH);
  assign last  = timed && (cnt == span - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      tries       <= '0;
      addr_q      <= '0;
      end_q       <= '0;
      fail_addr_q <= '0;
      data_q      <= '0;
      over        <= 1'b0;
      match       <= 1'b0;
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
    end else begin
      if (timed && !last) cnt <= cnt + CW'(1);
      else                cnt <= '0;
      case (st)
        S_IDLE: if (start) begin
          addr_q <= start_addr;
          end_q  <= end_addr;
          done_q <= 1'b0;
          fail_q <= 1'b0;
          tries  <= '0;
          over   <= 1'b0;
          st     <= S_FETCH;
        end
        S_FETCH: if (src_ack) begin
          data_q <= src_data;
          tries  <= '0;
          over   <= 1'b0;
          st     <= S_SETUP;
        end
        S_SETUP: if (last) begin
          if (!over) tries <= tries + TW'(1);
          st <= S_PULSE;
        end
        S_PULSE: if (last) st <= S_HOLD;
        S_HOLD: if (last) begin
          if (over) begin
            over <= 1'b0;
            if (addr_q == end_q) begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end else begin
              addr_q <= addr_q + AW'(1);
              st     <= S_FETCH;
            end
          end else begin
            st <= S_GAP;
          end
        end
        S_GAP: if (last) st <= S_READ;
        S_READ: if (last) begin
          match <= (rd_data == data_q);
          st    <= S_FLOAT;
        end
        S_FLOAT: if (last) begin
          if (match) begin
            over <= 1'b1;
            st   <= S_SETUP;
          end else if (tries == TW'(MAX_TRY)) begin
            fail_q      <= 1'b1;
            fail_addr_q <= addr_q;
            st          <= S_IDLE;
          end else begin
            st <= S_SETUP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign src_req   = (st == S_FETCH);
  assign ce_n      = (st != S_PULSE);
  assign oe_n      = (st != S_READ);
  assign wr_oe     = (st == S_SETUP) || (st == S_PULSE) || (st == S_HOLD);
  assign addr      = addr_q;
  assign wr_data   = data_q;
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign fail      = fail_q;
  assign fail_addr = fail_addr_q;
endmodule

// File: rtl/prom_prog_seq_chk.sv
module prom_prog_seq_chk #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          wr_oe,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wr_data,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic          src_req
);
  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!ce_n && !oe_n));
  // R7
  read_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n) !oe_n |-> !wr_oe);
  // R7
  drive_resume_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_oe) |-> oe_n && $past(oe_n));
  // R6
  pulse_driven_chk: assert property (@(posedge clk) disable iff (!rst_n) !ce_n |-> wr_oe);
  // R6
  pulse_stable_chk: assert property (@(posedge clk) disable iff (!rst_n) !ce_n |=> $stable(addr) && $stable(wr_data));
  // R6
  pulse_entry_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(ce_n) |-> $past(wr_oe) && $stable(addr) && $stable(wr_data));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> ce_n && oe_n && !wr_oe && !src_req);
  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !done && !fail);
endmodule

bind prom_prog_seq prom_prog_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .wr_oe(wr_oe),
  .addr(addr), .wr_data(wr_data), .busy(busy), .done(done), .fail(fail),
  .src_req(src_req)
);

// File: tb/prom_prog_seq_tb.sv
module prom_prog_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4, DW = 8;
  localparam int PULSE_CYC = 4, SETUP_CYC = 2, HOLD_CYC = 2, GAP_CYC = 2;
  localparam int READ_CYC = 2, FLOAT_CYC = 1, MAX_TRY = 25;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, src_ack = 1'b0;
  logic [AW-1:0] start_addr = '0, end_addr = '0;
  logic [DW-1:0] src_data = '0, rd_data;
  logic src_req, ce_n, oe_n, wr_oe, busy, done, fail;
  logic [AW-1:0] addr, fail_addr;
  logic [DW-1:0] wr_data;

  int total = 0, bad = 0;
  int need [16];
  int pcount [16];
  logic [DW-1:0] prog [16];

  typedef struct { int kind; int a; int d; int w; string req; } ev_t;
  ev_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  prom_prog_seq #(
    .AW(AW), .DW(DW), .PULSE_CYC(PULSE_CYC), .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC(HOLD_CYC), .GAP_CYC(GAP_CYC), .READ_CYC(READ_CYC),
    .FLOAT_CYC(FLOAT_CYC), .MAX_TRY(MAX_TRY)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .end_addr(end_addr), .src_req(src_req), .src_ack(src_ack),
    .src_data(src_data), .rd_data(rd_data), .ce_n(ce_n), .oe_n(oe_n),
    .addr(addr), .wr_data(wr_data), .wr_oe(wr_oe), .busy(busy),
    .done(done), .fail(fail), .fail_addr(fail_addr)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return DW'(a) * 8'd7 + 8'd3;
  endfunction

  always_comb
    rd_data = !oe_n ? ((pcount[addr] >= need[addr]) ? prog[addr] : 8'hFF) : 8'h00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic observe(input int kind, input int a, input int d, input int w);
    ev_t e;
    if (sbq.size() == 0) begin
      chk(1'b0, kind == 0 ? "R5 unexpected pulse" : "R5 unexpected verify", w, 0);
      return;
    end
    e = sbq.pop_front();
    chk(e.kind == kind, {e.req, " event kind"}, kind, e.kind);
    chk(e.a == a && e.d == d, {e.req, " address/data"}, a * 256 + d, e.a * 256 + e.d);
    chk(e.w == w, {e.req, " width"}, w, e.w);
  endtask

  // monitor: device model, byte source and scoreboard pops
  initial begin
    int ce_run = 0, oe_run = 0, stab = 0, hold_cnt = 0, off_run = 0, oe_hi = 0;
    bit hold_trk = 0, prev_wr = 0;
    int pa = 0, pd = 0;
    logic [AW-1:0] la = '0;
    logic [DW-1:0] ld = '0;
    forever begin
      @(negedge clk);
      src_ack  = src_req && !src_ack;
      src_data = pat(addr);
      if (rst_n) begin
        if (wr_oe && addr == la && wr_data == ld) stab++;
        else stab = wr_oe ? 1 : 0;
        la = addr; ld = wr_data;
        if (!ce_n) begin
          if (ce_run == 0) begin
            chk(stab >= SETUP_CYC + 1, "R6 setup before strobe", stab, SETUP_CYC + 1);
            pa = int'(addr); pd = int'(wr_data);
          end
          ce_run++;
        end else if (ce_run > 0) begin
          pcount[pa]++;
          prog[pa] = DW'(pd);
          observe(0, pa, pd, ce_run);
          ce_run = 0; hold_trk = 1; hold_cnt = 0;
        end
        if (hold_trk && ce_n) begin
          if (wr_oe && int'(addr) == pa && int'(wr_data) == pd) hold_cnt++;
          else begin
            chk(hold_cnt >= HOLD_CYC, "R6 hold after strobe", hold_cnt, HOLD_CYC);
            hold_trk = 0;
          end
        end
        if (!oe_n) begin
          if (oe_run == 0)
            chk(off_run >= GAP_CYC, "R7 release before read", off_run, GAP_CYC);
          if (wr_oe) chk(1'b0, "R7 drive during read", 1, 0);
          oe_run++;
        end else if (oe_run > 0) begin
          observe(1, int'(addr), int'(wr_data), oe_run);
          oe_run = 0;
        end
        if (wr_oe && !prev_wr)
          chk(oe_hi >= FLOAT_CYC, "R7 float before drive", oe_hi, FLOAT_CYC);
        prev_wr = wr_oe;
        off_run = wr_oe ? 0 : off_run + 1;
        oe_hi   = oe_n ? oe_hi + 1 : 0;
      end
    end
  end

  task automatic push(input int kind, input int a, input int w, input string req);
    ev_t e;
    e.kind = kind; e.a = a; e.d = int'(pat(AW'(a))); e.w = w; e.req = req;
    sbq.push_back(e);
  endtask

  // driver: predicts the strobe sequence, then launches the run
  task automatic run(input int sa, input int ea, input bit inject);
    for (int a = sa; a <= ea; a++) begin
      pcount[a] = 0;
      if (need[a] <= MAX_TRY) begin
        for (int i = 0; i < need[a]; i++) begin
          push(0, a, PULSE_CYC, "R2");
          push(1, a, READ_CYC, "R3");
        end
        push(0, a, 3 * need[a] * PULSE_CYC, "R4");
      end else begin
        for (int i = 0; i < MAX_TRY; i++) begin
          push(0, a, PULSE_CYC, "R5");
          push(1, a, READ_CYC, "R5");
        end
        break;
      end
    end
    start_addr = AW'(sa); end_addr = AW'(ea); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(busy && !done && !fail, "R10 start clears flags", {busy, done, fail}, 3'b100);
    if (inject) begin
      repeat (30) @(negedge clk);
      start_addr = 4'd9; end_addr = 4'd9; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R8 all predicted strobes seen", sbq.size(), 0);
    sbq.delete();
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin need[i] = 1; pcount[i] = 0; prog[i] = 8'hFF; end
    repeat (3) @(negedge clk);
    chk(ce_n && oe_n && !wr_oe && !busy && !done && !fail, "R1 reset state",
        {ce_n, oe_n, wr_oe, busy, done, fail}, 6'b110000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ce_n && oe_n && !busy, "R1 idle after reset", {ce_n, oe_n, busy}, 3'b110);

    // R8 R9: four locations, differing attempt counts, stray start mid-run (R10)
    need[2] = 1; need[3] = 3; need[4] = 2; need[5] = 1;
    run(2, 5, 1'b1);
    chk(done && !fail && !busy, "R8 done after last location", {done, fail, busy}, 3'b100);
    repeat (20) @(negedge clk);
    chk(done && !busy && ce_n && oe_n, "R10 done held while idle", {done, busy}, 2'b10);

    // R4: boundary, passes on the last allowed attempt
    need[7] = MAX_TRY;
    run(7, 7, 1'b0);
    chk(done && !fail, "R4 pass on final attempt", {done, fail}, 2'b10);

    // R5: defective location in the middle of a run
    need[10] = 1; need[11] = MAX_TRY + 1; need[12] = 1;
    run(10, 12, 1'b0);
    chk(fail && !done && !busy, "R5 defective flag", {fail, done, busy}, 3'b100);
    chk(fail_addr == 4'd11, "R5 failing address", int'(fail_addr), 11);
    repeat (20) @(negedge clk);
    chk(fail && ce_n && oe_n, "R10 fail held while idle", {fail, ce_n, oe_n}, 3'b111);

    // R9: per-location restart of the attempt count after a fail run
    need[12] = 2; need[13] = 1;
    run(12, 13, 1'b0);
    chk(done && !fail, "R9 run after fail", {done, fail}, 2'b10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule